// File: doc/BRIEF.md
# Serial FIFO Occupancy, Trigger and Ready-Pin Controller

This block tracks how full the receive and transmit FIFOs of an asynchronous serial controller are. It does not hold the data. A FIFO-control byte, written with a one-cycle strobe, does four things:

- switches both queues between FIFO operation and single-byte holding-register operation;
- picks the receive trigger depth;
- enables an extended queue depth;
- chooses between two behaviours for the active-low DMA ready pins.

The storage arrays and shifters sit next to this block. They report each byte they accept or remove through push and pop strobes, and they read back the counts and flags. The receive side also takes a character-timeout input from the receiver. It takes a line-status read strobe, which clears the overrun flag.

An asynchronous active-low reset is brought into the clock domain by a two-stage synchronizer. The internal state leaves reset two clock edges after `rst_n` rises.

Top module: `uart_fifo_occ`

## Requirements
- R1: After reset: `fifo_en`=0, both counts 0, `rx_trig`=0, `rx_overrun`=0, `tx_full`=0, `rx_rdy_n`=1 and `tx_rdy_n`=0.
- R2: A strobed control write stores its fields, and the stored values govern the cycles that follow:
  - bit 0 enables FIFO operation;
  - bit 3 selects ready mode 1 (clear selects mode 0);
  - bit 5 selects the extended depth;
  - bits [7:6] select the trigger code.
- R3: A control write with bit 1 set empties the receive count, and one with bit 2 set empties the transmit count. Neither bit is stored. A write that changes bit 0 or bit 5 against the stored value empties both counts.
- R4: Queue capacity is 1 with FIFOs disabled, 16 when enabled, and 64 when enabled with extended depth. A push at capacity is dropped and a pop at zero is ignored. A simultaneous accepted push and pop leave the count unchanged. `tx_full` is high when the transmit count equals capacity.
- R5: `rx_trig` is high while the receive count is at least the trigger level. The level is 1, 4, 8 or 14 for codes 00, 01, 10 and 11, and it is 1 with FIFOs disabled.
- R6: In mode 0, or with FIFOs disabled, `rx_rdy_n` is low in the cycle after one in which the receive count is non-zero, and high otherwise.
- R7: In mode 1 with FIFOs enabled, `rx_rdy_n` falls one cycle after the receive count reaches the trigger level, or after `rx_timeout` is seen with a non-zero count. It then stays low until one cycle after the count is zero.
- R8: In mode 0, or with FIFOs disabled, `tx_rdy_n` is low in the cycle after one in which the transmit count is zero, and high otherwise.
- R9: In mode 1 with FIFOs enabled, `tx_rdy_n` falls one cycle after the transmit count is zero. It then stays low until one cycle after the count equals capacity, and stays high from then until the count is zero again.
- R10: A receive push dropped for lack of room sets `rx_overrun` at the next edge. The flag holds until a cycle with `lsr_rd` high and no new drop. A drop in the same cycle as `lsr_rd` wins.
- R11: A clear in the same cycle as a push or pop on that queue leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control write data |
| rx_push | input | 1 | Receiver delivered a byte |
| rx_pop | input | 1 | Host read a received byte |
| rx_timeout | input | 1 | Receive character timeout |
| tx_push | input | 1 | Host wrote a byte to transmit |
| tx_pop | input | 1 | Transmitter took a byte |
| lsr_rd | input | 1 | Line-status read, clears overrun |
| fifo_en | output | 1 | FIFO operation enabled |
| rx_count | output | CW | Receive occupancy |
| tx_count | output | CW | Transmit occupancy |
| rx_trig | output | 1 | Receive count at or above trigger |
| rx_overrun | output | 1 | Receive overrun flag |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_rdy_n | output | 1 | Receive DMA ready, active low |
| tx_rdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
The hardest case to reach is the mode-1 transmit pin. It must stay high as the count falls back from the full 64-entry extended capacity, and fall again only at zero. Reaching it takes a control write that enables extended depth, then 64 consecutive pushes, then a long drain.

The receive latch under a timeout below the trigger level is equally hard to reach. It needs a partly filled queue, so the stimulus runs directed fill and drain sequences first. Random epochs then bias push and pop rates toward filling or draining. Rare random control writes land mid-traffic and cross the clear and depth-change cases.

// File: rtl/uart_fifo_occ_pkg.sv
package uart_fifo_occ_pkg;

  // Decoded, stored fields of the FIFO-control byte
  typedef struct packed {
    logic       en;     // FIFO operation on
    logic       mode1;  // ready-pin mode 1
    logic       ext;    // extended depth
    logic [1:0] trig;   // receive trigger code
  } fifo_cfg_t;

  localparam fifo_cfg_t CFG_RESET = '{en: 1'b0, mode1: 1'b0, ext: 1'b0, trig: 2'b00};

endpackage

// File: rtl/fifo_cfg_reg.sv
module fifo_cfg_reg
  import uart_fifo_occ_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [7:0] wdata,
  output fifo_cfg_t cfg,
  output logic      rx_clr,
  output logic      tx_clr
);

  fifo_cfg_t cfg_q, cfg_d;
  logic      geom_change;
  logic      unused_rsvd;

  assign unused_rsvd = wdata[4];

  always_comb begin
    cfg_d       = cfg_q;
    geom_change = wr && ((wdata[0] != cfg_q.en) || (wdata[5] != cfg_q.ext));
    if (wr) begin
      cfg_d.en    = wdata[0];
      cfg_d.mode1 = wdata[3];
      cfg_d.ext   = wdata[5];
      cfg_d.trig  = wdata[7:6];
    end
    rx_clr = (wr && wdata[1]) || geom_change;
    tx_clr = (wr && wdata[2]) || geom_change;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R2: a write lands in the stored fields on the next edge
  a_r2_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg.en == $past(wdata[0])) && (cfg.mode1 == $past(wdata[3])) &&
           (cfg.trig == $past(wdata[7:6])))
    else $error("R2 config not stored");

endmodule

// File: rtl/fifo_occ_cnt.sv
module fifo_occ_cnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] cap,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          drop
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_push, acc_pop;

  always_comb begin
    acc_push = push && (cnt_q < cap);
    acc_pop  = pop && (cnt_q != '0);
    cnt_d    = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (acc_push && !acc_pop)  cnt_d = cnt_q + 1'b1;
    else if (acc_pop && !acc_push)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign full  = (cnt_q >= cap);
  assign drop  = push && full && !clr;

  // R4: occupancy never goes past the configured capacity
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap)
    else $error("R4 count above capacity");

  // R11: a clear wins over any push or pop in the same cycle
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0))
    else $error("R11 clear did not empty count");

endmodule

// File: rtl/fifo_rdy_pins.sv
module fifo_rdy_pins
  import uart_fifo_occ_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_cfg_t     cfg,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_cap,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n
);

  logic latched_mode;
  logic rx_act_q, rx_act_d;
  logic tx_act_q, tx_act_d;

  assign latched_mode = cfg.en && cfg.mode1;

  always_comb begin
    if (latched_mode) begin
      if (rx_count == '0) rx_act_d = 1'b0;
      else                rx_act_d = rx_act_q || (rx_count >= rx_level) || rx_timeout;
      if (tx_count >= tx_cap)    tx_act_d = 1'b0;
      else if (tx_count == '0)   tx_act_d = 1'b1;
      else                       tx_act_d = tx_act_q;
    end else begin
      rx_act_d = (rx_count != '0);
      tx_act_d = (tx_count == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act_q <= 1'b0;
      tx_act_q <= 1'b1;
    end else begin
      rx_act_q <= rx_act_d;
      tx_act_q <= tx_act_d;
    end
  end

  assign rx_rdy_n = !rx_act_q;
  assign tx_rdy_n = !tx_act_q;

  // R6: mode 0 receive pin follows occupancy with one cycle of lag
  a_r6_rx_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    !latched_mode |=> (rx_rdy_n == ($past(rx_count) == '0)))
    else $error("R6 rx pin mode 0");

  // R7: once active in mode 1, the receive pin holds while data remains
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_mode && !rx_rdy_n && (rx_count != '0)) |=> !rx_rdy_n)
    else $error("R7 rx pin released early");

  // R8: mode 0 transmit pin active exactly when nothing is queued
  a_r8_tx_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    !latched_mode |=> (tx_rdy_n == ($past(tx_count) != '0)))
    else $error("R8 tx pin mode 0");

  // R9: a full queue releases the mode 1 transmit pin
  a_r9_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_mode && (tx_count >= tx_cap)) |=> tx_rdy_n)
    else $error("R9 tx pin not released at full");

endmodule

// File: rtl/uart_fifo_occ.sv
module uart_fifo_occ
  import uart_fifo_occ_pkg::*;
#(
  parameter int  BASE_DEPTH = 16,
  parameter int  EXT_DEPTH  = 64,
  localparam int CW         = $clog2(EXT_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          rx_timeout,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          lsr_rd,
  output logic          fifo_en,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_trig,
  output logic          rx_overrun,
  output logic          tx_full,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n
);

  localparam int NQ = 2;  // index 0 receive, 1 transmit

  // Reset: asserted at once, released after two clock edges
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fifo_cfg_t cfg;
  logic      rx_clr, tx_clr;

  fifo_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (fcr_wr),
    .wdata  (fcr_wdata),
    .cfg    (cfg),
    .rx_clr (rx_clr),
    .tx_clr (tx_clr)
  );

  // Capacity and trigger level from the stored configuration
  logic [CW-1:0] cap, rx_level;
  always_comb begin
    if (!cfg.en)      cap = CW'(1);
    else if (cfg.ext) cap = CW'(EXT_DEPTH);
    else              cap = CW'(BASE_DEPTH);
    if (!cfg.en) rx_level = CW'(1);
    else begin
      unique case (cfg.trig)
        2'b00:   rx_level = CW'(1);
        2'b01:   rx_level = CW'(4);
        2'b10:   rx_level = CW'(8);
        default: rx_level = CW'(14);
      endcase
    end
  end

  logic [NQ-1:0] clr_v, push_v, pop_v, full_v, drop_v;
  logic [CW-1:0] cnt_v [NQ];

  assign clr_v  = {tx_clr, rx_clr};
  assign push_v = {tx_push, rx_push};
  assign pop_v  = {tx_pop, rx_pop};

  for (genvar g = 0; g < NQ; g++) begin : g_q
    fifo_occ_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr_v[g]),
      .push  (push_v[g]),
      .pop   (pop_v[g]),
      .cap   (cap),
      .count (cnt_v[g]),
      .full  (full_v[g]),
      .drop  (drop_v[g])
    );
  end

  logic unused_tx_drop;
  assign unused_tx_drop = drop_v[1];

  // Overrun flag: a drop sets it, a line-status read clears it
  logic ovr_q, ovr_d;
  always_comb begin
    ovr_d = ovr_q;
    if (drop_v[0])   ovr_d = 1'b1;
    else if (lsr_rd) ovr_d = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  fifo_rdy_pins #(.CW(CW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg        (cfg),
    .rx_count   (cnt_v[0]),
    .rx_level   (rx_level),
    .rx_timeout (rx_timeout),
    .tx_count   (cnt_v[1]),
    .tx_cap     (cap),
    .rx_rdy_n   (rx_rdy_n),
    .tx_rdy_n   (tx_rdy_n)
  );

  assign fifo_en    = cfg.en;
  assign rx_count   = cnt_v[0];
  assign tx_count   = cnt_v[1];
  assign rx_trig    = (cnt_v[0] >= rx_level);
  assign rx_overrun = ovr_q;
  assign tx_full    = full_v[1];

  // R10: a rejected receive push raises overrun on the next edge
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_push && full_v[0] && !rx_clr) |=> rx_overrun)
    else $error("R10 overrun not raised");

  // R3: the receive clear bit empties the receive count
  a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fcr_wr && fcr_wdata[1]) |=> (rx_count == '0))
    else $error("R3 receive clear ignored");

endmodule

// File: tb/uart_fifo_occ_test.sv
module uart_fifo_occ_test;

  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic fcr_wr, rx_push, rx_pop, rx_timeout, tx_push, tx_pop, lsr_rd;
  logic [7:0] fcr_wdata;
  logic fifo_en, rx_trig, rx_overrun, tx_full, rx_rdy_n, tx_rdy_n;
  logic [CW-1:0] rx_count, tx_count;

  always #10 clk = ~clk;  // 50 MHz

  uart_fifo_occ uut (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_timeout(rx_timeout),
    .tx_push(tx_push), .tx_pop(tx_pop), .lsr_rd(lsr_rd),
    .fifo_en(fifo_en), .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig(rx_trig), .rx_overrun(rx_overrun), .tx_full(tx_full),
    .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int m_en, m_mode, m_ext, m_trig;
  int m_rxc, m_txc, m_ovr, m_rxa, m_txa;

  function automatic int m_cap();
    if (m_en == 0) return 1;
    return (m_ext != 0) ? 64 : 16;
  endfunction

  function automatic int m_lvl();
    if (m_en == 0) return 1;
    case (m_trig)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit lm;
    lm = (m_en != 0) && (m_mode != 0);
    chk("R2 fifo_en", int'(fifo_en), m_en);
    chk("R4 rx_count", int'(rx_count), m_rxc);
    chk("R4 tx_count", int'(tx_count), m_txc);
    chk("R4 tx_full", int'(tx_full), (m_txc == m_cap()) ? 1 : 0);
    chk("R5 rx_trig", int'(rx_trig), (m_rxc >= m_lvl()) ? 1 : 0);
    chk("R10 rx_overrun", int'(rx_overrun), m_ovr);
    chk(lm ? "R7 rx_rdy_n" : "R6 rx_rdy_n", int'(rx_rdy_n), 1 - m_rxa);
    chk(lm ? "R9 tx_rdy_n" : "R8 tx_rdy_n", int'(tx_rdy_n), 1 - m_txa);
  endtask

  task automatic model_step(input bit fw, input bit [7:0] fd, input bit rp, input bit ro,
                            input bit tp, input bit to, input bit tmo, input bit lr);
    int cap, lvl, nrxa, ntxa, nrxc, ntxc;
    bit rclr, tclr, geo;
    cap = m_cap();
    lvl = m_lvl();
    geo  = fw && ((int'(fd[0]) != m_en) || (int'(fd[5]) != m_ext));
    rclr = (fw && fd[1]) || geo;
    tclr = (fw && fd[2]) || geo;
    if (m_en != 0 && m_mode != 0) begin
      nrxa = (m_rxc == 0) ? 0 : ((m_rxa != 0 || m_rxc >= lvl || tmo) ? 1 : 0);
      ntxa = (m_txc == cap) ? 0 : ((m_txc == 0) ? 1 : m_txa);
    end else begin
      nrxa = (m_rxc != 0) ? 1 : 0;
      ntxa = (m_txc == 0) ? 1 : 0;
    end
    if (rp && m_rxc == cap && !rclr) m_ovr = 1;
    else if (lr) m_ovr = 0;
    nrxc = m_rxc;
    if (rclr) nrxc = 0;
    else nrxc = m_rxc + ((rp && m_rxc < cap) ? 1 : 0) - ((ro && m_rxc > 0) ? 1 : 0);
    ntxc = m_txc;
    if (tclr) ntxc = 0;
    else ntxc = m_txc + ((tp && m_txc < cap) ? 1 : 0) - ((to && m_txc > 0) ? 1 : 0);
    m_rxc = nrxc; m_txc = ntxc; m_rxa = nrxa; m_txa = ntxa;
    if (fw) begin
      m_en = fd[0]; m_mode = fd[3]; m_ext = fd[5]; m_trig = int'(fd[7:6]);
    end
  endtask

  task automatic tick(input bit fw, input bit [7:0] fd, input bit rp, input bit ro,
                      input bit tp, input bit to, input bit tmo, input bit lr);
    @(negedge clk);
    if (done) return;
    compare_all();
    fcr_wr = fw; fcr_wdata = fd; rx_push = rp; rx_pop = ro;
    tx_push = tp; tx_pop = to; rx_timeout = tmo; lsr_rd = lr;
    model_step(fw, fd, rp, ro, tp, to, tmo, lr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_fcr(input bit [7:0] d); tick(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rxp(input int n); for (int i = 0; i < n; i++) tick(0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic rxo(input int n); for (int i = 0; i < n; i++) tick(0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic txp(input int n); for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic txo(input int n); for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 1, 0, 0); endtask

  initial begin
    rst_n = 1'b0;
    fcr_wr = 0; fcr_wdata = 0; rx_push = 0; rx_pop = 0;
    tx_push = 0; tx_pop = 0; rx_timeout = 0; lsr_rd = 0;
    m_en = 0; m_mode = 0; m_ext = 0; m_trig = 0;
    m_rxc = 0; m_txc = 0; m_ovr = 0; m_rxa = 0; m_txa = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 fifo_en", int'(fifo_en), 0);
    chk("R1 rx_rdy_n", int'(rx_rdy_n), 1);
    chk("R1 tx_rdy_n", int'(tx_rdy_n), 0);
    chk("R1 rx_overrun", int'(rx_overrun), 0);

    // FIFOs off: holding register depth 1, second byte overruns
    rxp(2); idle(2);
    chk("R4 holding depth", int'(rx_count), 1);
    chk("R10 overrun set", int'(rx_overrun), 1);
    tick(0, 0, 0, 0, 0, 0, 0, 1); idle(1);
    chk("R10 overrun cleared", int'(rx_overrun), 0);

    // Enable with mode 1, trigger code 10 (8 bytes): enable change clears
    wr_fcr(8'h89); idle(1);
    chk("R3 enable change clears", int'(rx_count), 0);
    chk("R2 enabled", int'(fifo_en), 1);
    rxp(7); idle(3);
    chk("R7 below trigger", int'(rx_rdy_n), 1);
    rxp(1); idle(3);
    chk("R7 at trigger", int'(rx_rdy_n), 0);
    chk("R5 trigger flag", int'(rx_trig), 1);
    rxo(7); idle(3);
    chk("R7 held with one byte", int'(rx_rdy_n), 0);
    rxo(1); idle(3);
    chk("R7 released at empty", int'(rx_rdy_n), 1);
    rxp(2); idle(2);
    tick(0, 0, 0, 0, 0, 0, 1, 0); idle(3);
    chk("R7 timeout activates", int'(rx_rdy_n), 0);
    rxo(2); idle(3);

    // Extended depth, mode 1 transmit pin
    wr_fcr(8'hA9);
    txp(63); idle(3);
    chk("R9 active below full", int'(tx_rdy_n), 0);
    txp(1); idle(3);
    chk("R9 released at full", int'(tx_rdy_n), 1);
    chk("R4 extended capacity", int'(tx_count), 64);
    txp(1); idle(2);
    chk("R4 push at full dropped", int'(tx_count), 64);
    txo(1); idle(3);
    chk("R9 stays released", int'(tx_rdy_n), 1);
    txo(63); idle(3);
    chk("R9 active at empty", int'(tx_rdy_n), 0);

    // Mode 0, depth 16 (extended bit change clears)
    wr_fcr(8'h01);
    txp(1); idle(3);
    chk("R8 loaded", int'(tx_rdy_n), 1);
    txo(1); idle(3);
    chk("R8 empty", int'(tx_rdy_n), 0);
    rxp(1); idle(3);
    chk("R6 one byte", int'(rx_rdy_n), 0);
    rxo(1); idle(3);
    chk("R6 none", int'(rx_rdy_n), 1);

    // Clear bits against concurrent traffic
    rxp(3);
    tick(1, 8'h03, 1, 0, 0, 0, 0, 0); idle(2);
    chk("R11 clear beats push", int'(rx_count), 0);
    txp(2);
    tick(1, 8'h05, 0, 0, 0, 1, 0, 0); idle(2);
    chk("R3 transmit clear", int'(tx_count), 0);
    rxo(1); idle(2);
    chk("R4 pop at empty ignored", int'(rx_count), 0);

    // Random epochs
    for (int e = 0; e < 40; e++) begin
      int prp, pro, ptp, pto;
      prp = $urandom_range(10, 90); pro = $urandom_range(10, 90);
      ptp = $urandom_range(10, 90); pto = $urandom_range(10, 90);
      for (int c = 0; c < 500; c++) begin
        bit fw;
        bit [7:0] fd;
        fw = ($urandom_range(0, 299) == 0);
        fd = 8'($urandom);
        tick(fw, fd,
             $urandom_range(0, 99) < prp, $urandom_range(0, 99) < pro,
             $urandom_range(0, 99) < ptp, $urandom_range(0, 99) < pto,
             $urandom_range(0, 49) == 0, $urandom_range(0, 29) == 0);
      end
    end
    idle(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule